// File: doc/BRIEF.md
# One-Wire Bit Slot Controller

This block runs single time slots on an open-drain one-wire bus. Software writes a 4-bit command word and then polls a 4-bit status word until the busy bit clears. One command word covers each of these slots: holding the bus in reset, a presence-detect window, writing a 0, writing a 1, or reading one bit. A read uses the same slot as a write of 1. The controller releases the line early in that slot, so the sampled level is the bit that was read. Byte framing, device commands and the long reset waits are left to software.

All slot timings are given in microseconds and converted through a prescaler of `CLK_PER_US` clocks, which is 40 at the nominal 40 MHz. The block has no data stream. The command write strobe and the status read strobe are plain register strobes with no back-pressure. The block drives the bus only through `pull_low`, which is the enable of an external open-drain pull-down, and it observes the bus through `bus_in`.

Command word bits: [3] level (1 = short low pulse, 0 = long low pulse), [2] presence window, [1] hold reset, [0] start. Status word bits: [3] completion toggle, [2] busy, [1] presence seen, [0] sampled bit.

Top module: `ow_bitslot_ctrl`

## Requirements
- R1: After reset the status word reads 0000 and `pull_low` is 0.
- R2: An accepted command with bit1=1 and bit0=0 holds `pull_low` at 1 continuously until the next accepted command. An accepted command with bit1=0 and bit0=0 leaves the line released.
- R3: An accepted command with bit0=1, bit2=0 and bit3=1 starts a data slot. In that slot `pull_low` is 1 for exactly W1_LOW_US microseconds from the start, and the slot lasts SLOT_US microseconds.
- R4: An accepted command with bit0=1, bit2=0 and bit3=0 starts a data slot in which `pull_low` is 1 for exactly W0_LOW_US microseconds. The slot lasts SLOT_US microseconds.
- R5: A data slot samples `bus_in` in its first clock cycle after RD_SAMPLE_US microseconds and stores the value in status bit0. After a 1-slot with the line idle high, bit0 reads 1.
- R6: An accepted command with bit0=1 and bit2=1 runs a presence slot whatever bit3 is. The line is never driven, it is sampled in the first cycle after PRES_SAMPLE_US microseconds, and the inverse of the sample goes into status bit1. The slot lasts PRES_END_US microseconds.
- R7: Status bit2 (busy) is 1 for exactly the slot length in clock cycles.
- R8: Status bit3 toggles once when each slot completes.
- R9: A command written while a slot is running is ignored. It changes neither the slot's drive pattern nor the line state after the slot.
- R10: The status word output is captured only in a cycle where `stat_rd` is 1. It shows the state of that cycle and holds its value otherwise.
- R11: A command with bit0=0 starts no slot and leaves status bits 3, 1 and 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command word |
| stat_rd | input | 1 | Status read strobe |
| bus_in | input | 1 | Sampled bus level |
| pull_low | output | 1 | Open-drain pull-down enable |
| stat_rdata | output | 4 | Status word |

## Verification
The bench builds the block with CLK_PER_US=3, W1_LOW_US=2, RD_SAMPLE_US=4, W0_LOW_US=6, SLOT_US=8, PRES_SAMPLE_US=5 and PRES_END_US=7. With these values every slot is short enough to sweep all sixteen command words. For each command that starts a slot, a one-cycle external pull-down is placed at every cycle offset of the slot, so the exact drive widths, slot lengths and single sample instants are pinned down to the clock cycle. The prescaler value above 1 also checks the microsecond-to-cycle scaling.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    SK_DATA0 = 2'd0,
    SK_DATA1 = 2'd1,
    SK_PRES  = 2'd2
  } slot_kind_e;

  localparam int CMD_START = 0;
  localparam int CMD_HOLD  = 1;
  localparam int CMD_PRES  = 2;
  localparam int CMD_LEVEL = 3;

  localparam int ST_DATA = 0;
  localparam int ST_PRES = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_TGL  = 3;
endpackage

// File: rtl/ow_usec_timer.sv
module ow_usec_timer #(
  parameter int CLK_PER_US = 40,
  parameter int US_W       = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            active,
  output logic [US_W-1:0] us_q,
  output logic            tick,
  output logic            first
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      us_q  <= '0;
    end else if (start) begin
      div_q <= '0;
      us_q  <= '0;
    end else if (active) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign tick  = active && (div_q == DIV_LAST);
  assign first = active && (div_q == '0);

  AST_START_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (us_q == '0) && first); // R7
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
#(
  parameter int W1_LOW_US      = 6,
  parameter int RD_SAMPLE_US   = 15,
  parameter int W0_LOW_US      = 60,
  parameter int SLOT_US        = 65,
  parameter int PRES_SAMPLE_US = 70,
  parameter int PRES_END_US    = 72,
  parameter int US_W           = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  slot_kind_e      kind,
  input  logic [US_W-1:0] us,
  input  logic            tick,
  input  logic            first,
  output logic            drive,
  output logic            smp_data,
  output logic            smp_pres,
  output logic            done
);
  localparam logic [US_W-1:0] LOW1 = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] LOW0 = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] RSMP = US_W'(RD_SAMPLE_US);
  localparam logic [US_W-1:0] PSMP = US_W'(PRES_SAMPLE_US);
  localparam logic [US_W-1:0] DEND = US_W'(SLOT_US - 1);
  localparam logic [US_W-1:0] PEND = US_W'(PRES_END_US - 1);

  logic            is_pres;
  logic [US_W-1:0] low_us;
  logic [US_W-1:0] last_us;

  always_comb begin
    is_pres  = (kind == SK_PRES);
    low_us   = (kind == SK_DATA1) ? LOW1 : LOW0;
    last_us  = is_pres ? PEND : DEND;
    drive    = busy && !is_pres && (us < low_us);
    smp_data = busy && !is_pres && first && (us == RSMP);
    smp_pres = busy && is_pres && first && (us == PSMP);
    done     = busy && tick && (us == last_us);
  end

  AST_PRES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == SK_PRES) |-> !drive); // R6
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_data && kind == SK_DATA1) |-> !drive); // R5
  AST_ONE_SAMPLE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_data, smp_pres, done})); // R6
endmodule

// File: rtl/ow_cmd_status.sv
module ow_cmd_status
  import ow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_wdata,
  input  logic       stat_rd,
  input  logic       bus_in,
  input  logic       done,
  input  logic       smp_data,
  input  logic       smp_pres,
  output logic       start,
  output logic       busy,
  output slot_kind_e kind,
  output logic       hold,
  output logic [3:0] stat_rdata
);
  logic       accept;
  logic       tgl_q;
  logic       pres_q;
  logic       data_q;
  slot_kind_e next_kind;

  assign accept = cmd_wr && !busy;
  assign start  = accept && cmd_wdata[CMD_START];

  always_comb begin
    if (cmd_wdata[CMD_PRES])       next_kind = SK_PRES;
    else if (cmd_wdata[CMD_LEVEL]) next_kind = SK_DATA1;
    else                           next_kind = SK_DATA0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      kind <= SK_DATA0;
      hold <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      if (accept) hold <= cmd_wdata[CMD_HOLD] && !cmd_wdata[CMD_START];
      if (start) begin
        busy <= 1'b1;
        kind <= next_kind;
      end else if (done) begin
        busy  <= 1'b0;
        tgl_q <= !tgl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      if (smp_data) data_q <= bus_in;
      if (smp_pres) pres_q <= !bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_rdata <= '0;
    else if (stat_rd) begin
      stat_rdata[ST_TGL]  <= tgl_q;
      stat_rdata[ST_BUSY] <= busy;
      stat_rdata[ST_PRES] <= pres_q;
      stat_rdata[ST_DATA] <= data_q;
    end
  end

  AST_WR_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(kind) && $stable(hold)); // R9
  AST_DONE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (tgl_q != $past(tgl_q)) && !busy); // R8
  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> $stable(stat_rdata)); // R10
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_wdata[CMD_START] && !busy) |=> !busy); // R11
endmodule

// File: rtl/ow_bitslot_ctrl.sv
module ow_bitslot_ctrl
  import ow_pkg::*;
#(
  parameter int CLK_PER_US     = 40,
  parameter int W1_LOW_US      = 6,
  parameter int RD_SAMPLE_US   = 15,
  parameter int W0_LOW_US      = 60,
  parameter int SLOT_US        = 65,
  parameter int PRES_SAMPLE_US = 70,
  parameter int PRES_END_US    = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_wdata,
  input  logic       stat_rd,
  input  logic       bus_in,
  output logic       pull_low,
  output logic [3:0] stat_rdata
);
  localparam int LONGEST = (SLOT_US > PRES_END_US) ? SLOT_US : PRES_END_US;
  localparam int US_W    = $clog2(LONGEST + 1);

  logic            start, busy, hold, tick, first;
  logic            drive, smp_data, smp_pres, done;
  logic [US_W-1:0] us;
  slot_kind_e      kind;

  ow_cmd_status u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .stat_rd(stat_rd), .bus_in(bus_in), .done(done), .smp_data(smp_data),
    .smp_pres(smp_pres), .start(start), .busy(busy), .kind(kind),
    .hold(hold), .stat_rdata(stat_rdata)
  );

  ow_usec_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .active(busy),
    .us_q(us), .tick(tick), .first(first)
  );

  ow_slot_engine #(
    .W1_LOW_US(W1_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .W0_LOW_US(W0_LOW_US),
    .SLOT_US(SLOT_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .PRES_END_US(PRES_END_US), .US_W(US_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .busy(busy), .kind(kind), .us(us),
    .tick(tick), .first(first), .drive(drive), .smp_data(smp_data),
    .smp_pres(smp_pres), .done(done)
  );

  assign pull_low = busy ? drive : hold;

  AST_HOLD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold) |-> pull_low); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold) |-> !pull_low); // R2
endmodule

// File: tb/ow_bitslot_ctrl_tb_top.sv
module ow_bitslot_ctrl_tb_top;
  localparam int D     = 3;
  localparam int W1    = 2;
  localparam int SAMP  = 4;
  localparam int W0    = 6;
  localparam int SLOT  = 8;
  localparam int PSAMP = 5;
  localparam int PEND  = 7;
  localparam int WIN   = PEND * D + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [3:0] cmd_wdata = 4'd0;
  logic       stat_rd = 1'b1;
  logic       dev_low = 1'b0;
  logic       bus_in;
  logic       pull_low;
  logic [3:0] stat_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic e_tgl = 1'b0, e_pres = 1'b0, e_data = 1'b0;

  always #4 clk = ~clk;
  assign bus_in = ~(pull_low | dev_low);

  ow_bitslot_ctrl #(
    .CLK_PER_US(D), .W1_LOW_US(W1), .RD_SAMPLE_US(SAMP), .W0_LOW_US(W0),
    .SLOT_US(SLOT), .PRES_SAMPLE_US(PSAMP), .PRES_END_US(PEND)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .stat_rd(stat_rd), .bus_in(bus_in), .pull_low(pull_low),
    .stat_rdata(stat_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_slot(input logic [3:0] c, input int j, input int wr_at,
                         input logic [3:0] c2, output int npull, output int nrun);
    @(negedge clk);
    cmd_wdata = c;
    cmd_wr = 1'b1;
    npull = 0;
    nrun = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      cmd_wr = (k == wr_at);
      cmd_wdata = (k == wr_at) ? c2 : c;
      dev_low = (k == j);
      if (pull_low) npull++;
      if (stat_rdata[2]) nrun++;
    end
    cmd_wr = 1'b0;
    dev_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_idle(input logic [3:0] c);
    @(negedge clk);
    cmd_wdata = c;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int np, nr, exp_pull, exp_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 status", int'(stat_rdata), 0);
    check("R1 line", int'(pull_low), 0);

    // R2 R11: every command word without the start bit
    for (int c = 0; c < 16; c += 2) begin
      write_idle(4'(c));
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R2 hold level", int'(pull_low), (c & 2) ? 1 : 0);
      end
      check("R11 status kept", int'(stat_rdata), int'({e_tgl, 1'b0, e_pres, e_data}));
    end
    write_idle(4'd0);
    @(negedge clk);
    check("R2 released", int'(pull_low), 0);

    // R3..R8: every start command, one-cycle device pull at each offset
    for (int c = 1; c < 16; c += 2) begin
      for (int j = -1; j < WIN; j++) begin
        do_slot(4'(c), j, -1, 4'd0, np, nr);
        if (c & 4) begin
          exp_pull = 0;
          exp_len = PEND * D;
          e_pres = (j == PSAMP * D);
        end else if (c & 8) begin
          exp_pull = W1 * D;
          exp_len = SLOT * D;
          e_data = (j != SAMP * D);
        end else begin
          exp_pull = W0 * D;
          exp_len = SLOT * D;
          e_data = 1'b0;
        end
        e_tgl = ~e_tgl;
        if (c & 4) check("R6 no drive", np, exp_pull);
        else if (c & 8) check("R3 low width", np, exp_pull);
        else check("R4 low width", np, exp_pull);
        check("R7 busy length", nr, exp_len);
        check("R5 R6 R8 status", int'(stat_rdata), int'({e_tgl, 1'b0, e_pres, e_data}));
        check("R2 line after slot", int'(pull_low), 0);
      end
    end

    // R9: writes during a running 1-slot
    do_slot(4'b1001, -1, 3, 4'b0001, np, nr);
    e_tgl = ~e_tgl;
    e_data = 1'b1;
    check("R9 drive kept", np, W1 * D);
    check("R9 length kept", nr, SLOT * D);
    do_slot(4'b1001, -1, 2, 4'b0010, np, nr);
    e_tgl = ~e_tgl;
    check("R9 hold ignored", int'(pull_low), 0);
    check("R9 status", int'(stat_rdata), int'({e_tgl, 1'b0, e_pres, e_data}));

    // R10: no read strobe, status output frozen
    @(negedge clk);
    stat_rd = 1'b0;
    do_slot(4'b0001, -1, -1, 4'd0, np, nr);
    check("R10 frozen", int'(stat_rdata), int'({e_tgl, 1'b0, e_pres, e_data}));
    e_tgl = ~e_tgl;
    e_data = 1'b0;
    stat_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 refreshed", int'(stat_rdata), int'({e_tgl, 1'b0, e_pres, e_data}));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule